// File: doc/BRIEF.md
# ALU Operation Decoder with 32-bit ALU

This block turns the two-bit operation class from an instruction decoder, together with the six-bit function field of a register-register instruction, into a three-bit operation code. It then applies that operation to two 32-bit operands. The class either forces an addition (address forming for loads and stores) or a subtraction (equality test for branches), or it hands the choice to the function field. The block reports the result and a flag that is high when the result is zero. A branch-if-equal decision uses that flag.

The block is purely combinational. Five of the eight operation codes are used: 000 AND, 001 OR, 010 add, 110 subtract, 111 signed set-on-less-than. The decoder emits code 011 for a function field it does not recognise, and every unused code gives a result of zero.

Top module: `aluUnit`

## Requirements
- R1: With opClass 00, opCode is 010 and result is opA + opB for every funct value.
- R2: With opClass bit 0 set (01 or 11), opCode is 110 and result is opA - opB for every funct value.
- R3: With opClass 10, funct[3:0] = 0000 gives opCode 010 (add) and 0010 gives opCode 110 (subtract). funct[5:4] have no effect on the decode.
- R4: With opClass 10, funct[3:0] = 0100 gives opCode 000 and result opA & opB. funct[3:0] = 0101 gives opCode 001 and result opA | opB.
- R5: With opClass 10, funct[3:0] = 1010 gives opCode 111. Result bit 0 is 1 exactly when opA < opB as signed 32-bit values, and bits 31:1 are 0.
- R6: With opClass 10 and any other funct[3:0], opCode is 011 and result is 0.
- R7: zero is 1 exactly when all 32 bits of result are 0.
- R8: Addition and subtraction wrap modulo 2^32. For example, FFFFFFFF + 1 gives 0 with zero high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| opClass | input | 2 | Operation class from the instruction decoder |
| funct | input | 6 | Function field of a register-register instruction |
| opA | input | 32 | First operand |
| opB | input | 32 | Second operand |
| opCode | output | 3 | Decoded ALU operation code |
| result | output | 32 | ALU result |
| zero | output | 1 | High when result is all zeros |

## Verification
The hardest cases are the signed comparison at the sign boundary, where the raw difference overflows, and the overlap of class 11 with the function decode. Random operands almost never reach the boundary operand pairs, such as 80000000 against 7FFFFFFF, or equal values. The stimulus therefore places these pairs directly. It then sweeps all 64 funct values under every class, so that the priority of class bit 0 and the don't-care upper funct bits are both exercised.

// File: rtl/aluPkg.sv
package aluPkg;
  typedef enum logic [2:0] {
    OP_AND  = 3'b000,
    OP_OR   = 3'b001,
    OP_ADD  = 3'b010,
    OP_NONE = 3'b011,
    OP_SUB  = 3'b110,
    OP_SLT  = 3'b111
  } aluCode_e;

  // strobes from the decoder to the datapath
  typedef struct packed {
    logic selAnd;
    logic selOr;
    logic selArith;
    logic selSlt;
    logic invertB;
  } aluStrobe_t;
endpackage

// File: rtl/aluDecode.sv
module aluDecode
  import aluPkg::*;
#(
  parameter int CLASS_W = 2,
  parameter int FUNCT_W = 6
) (
  input  logic [CLASS_W-1:0] opClass,
  input  logic [FUNCT_W-1:0] funct,
  output logic [2:0]         opCode,
  output aluStrobe_t         strobe
);
  aluCode_e code;

  always_comb begin
    if (opClass[0])                 code = OP_SUB;
    else if (!opClass[CLASS_W-1])   code = OP_ADD;
    else begin
      casez (funct)
        6'b??0000: code = OP_ADD;
        6'b??0010: code = OP_SUB;
        6'b??0100: code = OP_AND;
        6'b??0101: code = OP_OR;
        6'b??1010: code = OP_SLT;
        default:   code = OP_NONE;
      endcase
    end
  end

  always_comb begin
    strobe = '0;
    unique case (code)
      OP_AND: strobe.selAnd = 1'b1;
      OP_OR:  strobe.selOr  = 1'b1;
      OP_ADD: strobe.selArith = 1'b1;
      OP_SUB: begin strobe.selArith = 1'b1; strobe.invertB = 1'b1; end
      OP_SLT: begin strobe.selSlt = 1'b1;   strobe.invertB = 1'b1; end
      default: strobe = '0;
    endcase
  end

  assign opCode = code;
endmodule

// File: rtl/aluCore.sv
module aluCore
  import aluPkg::*;
#(
  parameter int WIDTH = 32
) (
  input  aluStrobe_t       strobe,
  input  logic [WIDTH-1:0] opA,
  input  logic [WIDTH-1:0] opB,
  output logic [WIDTH-1:0] result,
  output logic             zero
);
  localparam int MSB = WIDTH - 1;

  logic [WIDTH-1:0] bIn;
  logic [WIDTH-1:0] sum;
  logic             lessThan;

  // one adder serves add, subtract and compare
  assign bIn = strobe.invertB ? ~opB : opB;
  assign sum = opA + bIn + {{(WIDTH-1){1'b0}}, strobe.invertB};

  // signed less-than, corrected when the difference overflows
  assign lessThan = (opA[MSB] != opB[MSB]) ? opA[MSB] : sum[MSB];

  always_comb begin
    result = ({WIDTH{strobe.selAnd}}   & (opA & opB))
           | ({WIDTH{strobe.selOr}}    & (opA | opB))
           | ({WIDTH{strobe.selArith}} & sum)
           | ({WIDTH{strobe.selSlt}}   & {{(WIDTH-1){1'b0}}, lessThan});
  end

  assign zero = (result == '0);
endmodule

// File: rtl/aluUnit.sv
module aluUnit
  import aluPkg::*;
#(
  parameter int WIDTH   = 32,
  parameter int CLASS_W = 2,
  parameter int FUNCT_W = 6
) (
  input  logic [CLASS_W-1:0] opClass,
  input  logic [FUNCT_W-1:0] funct,
  input  logic [WIDTH-1:0]   opA,
  input  logic [WIDTH-1:0]   opB,
  output logic [2:0]         opCode,
  output logic [WIDTH-1:0]   result,
  output logic               zero
);
  aluStrobe_t strobe;

  aluDecode #(.CLASS_W(CLASS_W), .FUNCT_W(FUNCT_W)) i_decode (
    .opClass(opClass), .funct(funct), .opCode(opCode), .strobe(strobe)
  );

  aluCore #(.WIDTH(WIDTH)) i_core (
    .strobe(strobe), .opA(opA), .opB(opB), .result(result), .zero(zero)
  );
endmodule

// File: rtl/aluUnitChk.sv
module aluUnitChk #(
  parameter int WIDTH   = 32,
  parameter int CLASS_W = 2,
  parameter int FUNCT_W = 6
) (
  input logic [CLASS_W-1:0] opClass,
  input logic [FUNCT_W-1:0] funct,
  input logic [WIDTH-1:0]   opA,
  input logic [WIDTH-1:0]   opB,
  input logic [2:0]         opCode,
  input logic [WIDTH-1:0]   result,
  input logic               zero
);
  always_comb begin
    // R1
    add_class_chk: assert (!(opClass == '0) || (opCode == 3'b010 && result == opA + opB));
    // R2
    sub_class_chk: assert (!opClass[0] || (opCode == 3'b110 && result == opA - opB));
    // R4
    and_or_chk: assert ((opCode != 3'b000 || result == (opA & opB)) &&
                        (opCode != 3'b001 || result == (opA | opB)));
    // R5
    slt_upper_chk: assert (opCode != 3'b111 || result[WIDTH-1:1] == '0);
    // R6
    unused_code_chk: assert (!(opCode == 3'b011 || opCode == 3'b100 || opCode == 3'b101) ||
                             result == '0);
    // R7
    zero_flag_chk: assert (zero == (result == '0));
    // R3
    funct_upper_chk: assert (!(opClass == 2'b10 && funct[3:0] == 4'b0000) || opCode == 3'b010);
  end
endmodule

bind aluUnit aluUnitChk #(.WIDTH(WIDTH), .CLASS_W(CLASS_W), .FUNCT_W(FUNCT_W)) i_chk (
  .opClass(opClass), .funct(funct), .opA(opA), .opB(opB),
  .opCode(opCode), .result(result), .zero(zero)
);

// File: tb/test_aluUnit.sv
`timescale 1ns/1ps
module test_aluUnit;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [1:0]  opClass = '0;
  logic [5:0]  funct = '0;
  logic [31:0] opA = '0;
  logic [31:0] opB = '0;
  logic [2:0]  opCode;
  logic [31:0] result;
  logic        zero;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  aluUnit i_aluUnit (
    .opClass(opClass), .funct(funct), .opA(opA), .opB(opB),
    .opCode(opCode), .result(result), .zero(zero)
  );

  // behavioural reference: returns {code, result}
  function automatic logic [34:0] refModel(logic [1:0] c, logic [5:0] f,
                                           logic [31:0] a, logic [31:0] b);
    logic [2:0]  code;
    logic [31:0] r;
    if (c[0]) code = 3'b110;
    else if (c == 2'b00) code = 3'b010;
    else begin
      case (f[3:0])
        4'd0:  code = 3'b010;
        4'd2:  code = 3'b110;
        4'd4:  code = 3'b000;
        4'd5:  code = 3'b001;
        4'd10: code = 3'b111;
        default: code = 3'b011;
      endcase
    end
    case (code)
      3'b000: r = a & b;
      3'b001: r = a | b;
      3'b010: r = 32'(longint'(a) + longint'(b));
      3'b110: r = 32'(longint'(a) - longint'(b));
      3'b111: r = ($signed(a) < $signed(b)) ? 32'd1 : 32'd0;
      default: r = 32'd0;
    endcase
    return {code, r};
  endfunction

  task automatic apply(input logic [1:0] c, input logic [5:0] f,
                       input logic [31:0] a, input logic [31:0] b, input string req);
    logic [34:0] exp;
    logic        expZero;
    @(posedge clk);
    opClass <= c; funct <= f; opA <= a; opB <= b;
    @(negedge clk);
    exp = refModel(c, f, a, b);
    expZero = (exp[31:0] == 32'd0);
    checks++;
    if (opCode !== exp[34:32] || result !== exp[31:0] || zero !== expZero) begin
      errors++;
      $display("FAIL %s: class=%b funct=%b a=%h b=%h got code=%b res=%h zero=%b exp code=%b res=%h zero=%b",
               req, c, f, a, b, opCode, result, zero, exp[34:32], exp[31:0], expZero);
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000 && !finished) begin
      errors++;
      $display("FAIL watchdog: expired after %0d cycles, expected completion", cycles);
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    rstN = 1'b1;
    // reset state: all-zero inputs, add of zeros, zero flag high (R1 R7)
    apply(2'b00, 6'd0, 32'd0, 32'd0, "R1_reset");
    // R1: class 00 ignores funct
    for (int f = 0; f < 64; f++) apply(2'b00, 6'(f), 32'h1234_5678, 32'h0F0F_0F0F, "R1");
    // R2: class 01 and 11 force subtract
    for (int f = 0; f < 64; f++) apply(2'b01, 6'(f), 32'h0000_0010, 32'h0000_0020, "R2");
    for (int f = 0; f < 64; f++) apply(2'b11, 6'(f), 32'hAAAA_0000, 32'h0000_5555, "R2");
    // R3 R4 R5 R6: full funct sweep under class 10
    for (int f = 0; f < 64; f++) apply(2'b10, 6'(f), 32'hF0F0_1234, 32'h0FF0_4321, "R3_R6");
    for (int f = 0; f < 64; f++) apply(2'b10, 6'(f), 32'h8000_0000, 32'h0000_0001, "R5_R6");
    // R3: canonical and upper-bit variants
    apply(2'b10, 6'b100000, 32'd7, 32'd9, "R3");
    apply(2'b10, 6'b010010, 32'd7, 32'd9, "R3");
    // R4
    apply(2'b10, 6'b100100, 32'hFFFF_0000, 32'h0F0F_F0F0, "R4");
    apply(2'b10, 6'b100101, 32'hFFFF_0000, 32'h0F0F_F0F0, "R4");
    // R5 boundary pairs
    apply(2'b10, 6'b101010, 32'h8000_0000, 32'h7FFF_FFFF, "R5");
    apply(2'b10, 6'b101010, 32'h7FFF_FFFF, 32'h8000_0000, "R5");
    apply(2'b10, 6'b101010, 32'h0000_0005, 32'h0000_0005, "R5");
    apply(2'b10, 6'b101010, 32'hFFFF_FFFF, 32'h0000_0000, "R5");
    apply(2'b10, 6'b101010, 32'h0000_0003, 32'h0000_0004, "R5");
    // R6
    apply(2'b10, 6'b111111, 32'hDEAD_BEEF, 32'h1, "R6");
    // R7 R8
    apply(2'b00, 6'd0, 32'hFFFF_FFFF, 32'd1, "R8");
    apply(2'b01, 6'd0, 32'd0, 32'd1, "R8");
    apply(2'b01, 6'd0, 32'h1357_9BDF, 32'h1357_9BDF, "R7");
    apply(2'b10, 6'b100100, 32'hF0F0_F0F0, 32'h0F0F_0F0F, "R7");
    // random mix
    for (int i = 0; i < 2000; i++)
      apply(2'($urandom), 6'($urandom), $urandom, $urandom, "R1_R8_random");
    finished = 1;
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule